// File: doc/BRIEF.md
# Multiplexed Asynchronous Parallel Memory Master

This block lets an internal transfer channel read and write 32-bit words in an asynchronous external memory reached through sixteen shared address/data lines. A request carries a 24-bit word address, a direction bit and, for writes, a 32-bit data word. The block first places the external address on the shared lines under an address-latch strobe. It then runs one data strobe for each narrow beat. Each narrow datum is moved to or from the matching lane of the 32-bit word.

Two bus widths are supported. In byte mode the full 24-bit address is sent in two latch phases and a word takes four byte beats. In halfword mode only a 16-bit address is sent in one latch phase and a word takes two halfword beats. Every beat advances the external address by one and latches it again. The width of each data strobe is set by a 5-bit cycle count that is captured when the request is accepted.

The controller is a five-state machine:
- `ST_IDLE` accepts a request. It moves to `ST_ADDR_HI` in byte mode and to `ST_ADDR_LO` in halfword mode.
- `ST_ADDR_HI` always moves to `ST_ADDR_LO`.
- `ST_ADDR_LO` always moves to `ST_STROBE`.
- `ST_STROBE` holds until its timer expires. It then moves to `ST_FINISH` on the last beat, or back to `ST_ADDR_HI` or `ST_ADDR_LO` for the next beat.
- `ST_FINISH` always returns to `ST_IDLE`.

Top module: `apm_port`

## Requirements
- R1: While reset is held and after it is released: `rd_n` and `wr_n` are 1, `ale` is 0, `ad_oe` is 0, `done` is 0 and `req_ready` is 1.
- R2: In byte mode (`cfg_wide`=0) each beat has two consecutive `ale` cycles. The first drives `{8'h00, addr[23:16]}` and the second drives `addr[15:0]`. A word therefore shows 8 `ale` cycles, and carries out of bit 15 reach the upper byte.
- R3: In halfword mode (`cfg_wide`=1) each beat has a single `ale` cycle that drives `addr[15:0]`, so a word shows 2 `ale` cycles.
- R4: Every `rd_n` or `wr_n` low pulse lasts exactly N cycles. N is `cfg_cycles` (0 to 31), with values 0 and 1 treated as 2.
- R5: A byte-mode write puts byte k of `req_wdata` (bits 8k+7:8k) on `ad_out[7:0]` at address base+k, for k = 0 to 3, with `ad_out[15:8]` at 0.
- R6: A halfword-mode write puts `req_wdata[15:0]` at address base and `req_wdata[31:16]` at base+1.
- R7: A byte-mode read returns a word whose bits 8k+7:8k hold the byte read at base+k, sampled on the last cycle of each read strobe.
- R8: A halfword-mode read returns a word whose bits 15:0 hold the halfword at base and bits 31:16 hold the halfword at base+1.
- R9: `ad_oe` is 1 during `ale` cycles and write strobes. It is 0 during read strobes and whenever no address or write data is driven.
- R10: `done` pulses for exactly one cycle per word, with `rdata` valid in that cycle. `req_ready` is 1 only in idle, which follows the `done` cycle.
- R11: `cfg_wide` and `cfg_cycles` are sampled at request acceptance. Changing them during a transfer leaves the beat count, latch phases and strobe widths of that transfer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wide | input | 1 | 0: byte data with 24-bit address; 1: halfword data with 16-bit address |
| cfg_cycles | input | 5 | Data strobe width in clock cycles (minimum 2) |
| req_valid | input | 1 | Request present; accepted while `req_ready` is 1 |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 24 | External base address of the word |
| req_wdata | input | 32 | Word to write |
| req_ready | output | 1 | Block idle and able to accept a request |
| done | output | 1 | One-cycle pulse at word completion |
| rdata | output | 32 | Assembled read word, valid with `done` |
| ad_out | output | 16 | Value driven onto the shared lines |
| ad_oe | output | 1 | Output enable for the shared lines |
| ad_in | input | 16 | Value sampled from the shared lines |
| ale | output | 1 | Address-latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The bench drives a word whose byte-mode address crosses a 64K boundary. A design that failed to carry the beat increment into the upper address byte would latch the wrong upper byte for the last two beats. Cycle values 0, 1, 3 and 31 test the clamp and the full range. An off-by-one timer would show a strobe one cycle short or long, and a missing clamp would give a one-cycle or zero-cycle strobe. Reads fill every lane with distinct values, so a lane order reversed or shifted from little-endian is visible in `rdata`. Another test changes the configuration inputs in the middle of a transfer, which catches a design that reads them live instead of capturing them at acceptance.

// File: rtl/apm_pkg.sv
package apm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ADDR_HI = 3'd1,
        ST_ADDR_LO = 3'd2,
        ST_STROBE  = 3'd3,
        ST_FINISH  = 3'd4
    } apm_state_e;

    localparam int unsigned APM_MIN_CYCLES = 2;

endpackage

// File: rtl/apm_cycle_timer.sv
module apm_cycle_timer #(
    parameter int unsigned CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          last
);
    localparam logic [CW-1:0] MIN_VAL = CW'(apm_pkg::APM_MIN_CYCLES);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] start_val;

    assign start_val = (load_val < MIN_VAL) ? MIN_VAL : load_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= start_val;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = run && (cnt_q == CW'(1));

endmodule

// File: rtl/apm_lane_packer.sv
module apm_lane_packer #(
    parameter int unsigned DW = 32,
    parameter int unsigned LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          shift,
    input  logic          wide,
    input  logic [LW-1:0] lane_in,
    output logic [LW-1:0] lane_out,
    output logic [DW-1:0] word
);
    localparam int unsigned NW = LW / 2;

    logic [DW-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= load_data;
        end else if (shift) begin
            if (wide) begin
                word_q <= {lane_in, word_q[DW-1:LW]};
            end else begin
                word_q <= {lane_in[NW-1:0], word_q[DW-1:NW]};
            end
        end
    end

    assign lane_out = wide ? word_q[LW-1:0] : {{(LW-NW){1'b0}}, word_q[NW-1:0]};
    assign word     = word_q;

endmodule

// File: rtl/apm_port.sv
module apm_port #(
    parameter int unsigned AW = 24,
    parameter int unsigned DW = 32,
    parameter int unsigned PW = 16,
    parameter int unsigned CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wide,
    input  logic [CW-1:0] cfg_cycles,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic [PW-1:0] ad_out,
    output logic          ad_oe,
    input  logic [PW-1:0] ad_in,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n
);
    import apm_pkg::*;

    localparam int unsigned NARROW_BEATS = DW / (PW / 2);
    localparam int unsigned WIDE_BEATS   = DW / PW;
    localparam int unsigned BCW          = $clog2(NARROW_BEATS + 1);
    localparam int unsigned HI_BITS      = AW - PW;

    apm_state_e    state_q, state_d;
    logic          wr_q, wide_q;
    logic [CW-1:0] cyc_q;
    logic [AW-1:0] addr_q;
    logic [BCW-1:0] beats_q;

    logic          accept;
    logic          beat_end;
    logic          tmr_last;
    logic [PW-1:0] lane_out;
    logic [PW-1:0] lane_in;

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign beat_end = (state_q == ST_STROBE) && tmr_last;
    assign lane_in  = wr_q ? '0 : ad_in;

    apm_cycle_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_q == ST_ADDR_LO),
        .load_val (cyc_q),
        .run      (state_q == ST_STROBE),
        .last     (tmr_last)
    );

    apm_lane_packer #(.DW(DW), .LW(PW)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_data (req_write ? req_wdata : '0),
        .shift     (beat_end),
        .wide      (wide_q),
        .lane_in   (lane_in),
        .lane_out  (lane_out),
        .word      (rdata)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = cfg_wide ? ST_ADDR_LO : ST_ADDR_HI;
            ST_ADDR_HI: state_d = ST_ADDR_LO;
            ST_ADDR_LO: state_d = ST_STROBE;
            ST_STROBE: begin
                if (tmr_last) begin
                    if (beats_q == BCW'(1)) state_d = ST_FINISH;
                    else                    state_d = wide_q ? ST_ADDR_LO : ST_ADDR_HI;
                end
            end
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Transfer context captured at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            wide_q  <= 1'b0;
            cyc_q   <= '0;
            addr_q  <= '0;
            beats_q <= '0;
        end else if (accept) begin
            wr_q    <= req_write;
            wide_q  <= cfg_wide;
            cyc_q   <= cfg_cycles;
            addr_q  <= req_addr;
            beats_q <= cfg_wide ? BCW'(WIDE_BEATS) : BCW'(NARROW_BEATS);
        end else if (beat_end) begin
            addr_q  <= addr_q + 1'b1;
            beats_q <= beats_q - 1'b1;
        end
    end

    // Outputs
    always_comb begin
        ale       = 1'b0;
        ad_oe     = 1'b0;
        ad_out    = '0;
        rd_n      = 1'b1;
        wr_n      = 1'b1;
        req_ready = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_ADDR_HI: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = {{(PW-HI_BITS){1'b0}}, addr_q[AW-1:PW]};
            end
            ST_ADDR_LO: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = addr_q[PW-1:0];
            end
            ST_STROBE: begin
                if (wr_q) begin
                    wr_n   = 1'b0;
                    ad_oe  = 1'b1;
                    ad_out = lane_out;
                end else begin
                    rd_n   = 1'b0;
                end
            end
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/apm_port_chk.sv
module apm_port_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic done,
    input logic ad_oe,
    input logic ale,
    input logic rd_n,
    input logic wr_n
);
    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n));
    // R4
    rd_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(rd_n) |=> !rd_n);
    // R4
    wr_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(wr_n) |=> !wr_n);
    // R9
    read_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !ad_oe);
    // R9
    write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n) !wr_n |-> ad_oe);
    // R9
    ale_drive_chk: assert property (@(posedge clk) disable iff (!rst_n) ale |-> (ad_oe && rd_n && wr_n));
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    // R10
    done_then_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> req_ready);
    // R10
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) (ale || done) |-> !req_ready);
endmodule

bind apm_port apm_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .ad_oe     (ad_oe),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n)
);

// File: tb/sim_apm_port.sv
module sim_apm_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wide = 1'b0;
    logic [4:0]  cfg_cycles = 5'd2;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, done;
    logic [31:0] rdata;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic [15:0] ad_in;
    logic        ale, rd_n, wr_n;

    always #5 clk = ~clk;

    apm_port u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_cycles(cfg_cycles),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .done(done), .rdata(rdata),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
    );

    int checks = 0;
    int errors = 0;

    // Latched-address memory model
    logic [7:0]  mem8  [256];
    logic [15:0] mem16 [256];
    logic [7:0]  a_hi = '0;
    logic [15:0] a_lo = '0;
    bit          ale_d = 1'b0;
    bit          m_wide = 1'b0;
    int ale_cnt, strb_cnt, strb_min, strb_max, run_len, oe_bad, up_bad;

    assign ad_in = !rd_n ? (m_wide ? mem16[a_lo[7:0]] : {8'h00, mem8[a_lo[7:0]]}) : 16'hDEAD;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ale) begin
                ale_cnt++;
                if (!m_wide && !ale_d) begin
                    a_hi = ad_out[7:0];
                    if (ad_out[15:8] != 8'h00) up_bad++;
                end else begin
                    a_lo = ad_out;
                end
            end
            ale_d = ale;
            if (!wr_n) begin
                if (!ad_oe) oe_bad++;
                if (m_wide) mem16[a_lo[7:0]] = ad_out;
                else begin
                    mem8[a_lo[7:0]] = ad_out[7:0];
                    if (ad_out[15:8] != 8'h00) up_bad++;
                end
            end
            if (!rd_n && ad_oe) oe_bad++;
            if (!rd_n || !wr_n) run_len++;
            else if (run_len != 0) begin
                strb_cnt++;
                if (run_len < strb_min) strb_min = run_len;
                if (run_len > strb_max) strb_max = run_len;
                run_len = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    task automatic do_xfer(input bit wr, input logic [23:0] a, input logic [31:0] wd,
                           input bit wide, input logic [4:0] cyc, input bit alter,
                           output logic [31:0] rd);
        int n;
        ale_cnt = 0; strb_cnt = 0; strb_min = 1000; strb_max = 0;
        run_len = 0; oe_bad = 0; up_bad = 0;
        m_wide = wide;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        cfg_wide = wide; cfg_cycles = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        if (alter) begin
            cfg_wide = ~wide;
            cfg_cycles = 5'd9;
        end
        n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        #1;
        chk_eq("R10 done pulse seen", {31'd0, done}, 32'd1);
        chk_eq("R10 not ready during done", {31'd0, req_ready}, 32'd0);
        rd = rdata;
        @(negedge clk); #1;
        chk_eq("R10 done single cycle", {31'd0, done}, 32'd0);
        chk_eq("R10 ready after done", {31'd0, req_ready}, 32'd1);
    endtask

    task automatic chk_phys(input bit wide, input logic [4:0] cyc);
        int expn;
        expn = (cyc < 2) ? 2 : int'(cyc);
        if (wide) chk_eq("R3 ale cycles per word", ale_cnt, 2);
        else      chk_eq("R2 ale cycles per word", ale_cnt, 8);
        chk_eq("R4 strobe count", strb_cnt, wide ? 2 : 4);
        chk_eq("R4 shortest strobe", strb_min, expn);
        chk_eq("R4 longest strobe", strb_max, expn);
        chk_eq("R9 bus drive errors", oe_bad, 0);
        chk_eq("R2 upper lines zero", up_bad, 0);
    endtask

    task automatic t_reset;
        #1;
        chk_eq("R1 rd_n in reset", {31'd0, rd_n}, 32'd1);
        chk_eq("R1 ad_oe in reset", {31'd0, ad_oe}, 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk_eq("R1 rd_n", {31'd0, rd_n}, 32'd1);
        chk_eq("R1 wr_n", {31'd0, wr_n}, 32'd1);
        chk_eq("R1 ale", {31'd0, ale}, 32'd0);
        chk_eq("R1 ad_oe", {31'd0, ad_oe}, 32'd0);
        chk_eq("R1 done", {31'd0, done}, 32'd0);
        chk_eq("R1 req_ready", {31'd0, req_ready}, 32'd1);
    endtask

    task automatic t_byte_write;
        logic [31:0] rd;
        do_xfer(1'b1, 24'h12FFFE, 32'hA1B2C3D4, 1'b0, 5'd3, 1'b0, rd);
        chk_phys(1'b0, 5'd3);
        chk_eq("R5 byte0 at base", mem8[8'hFE], 8'hD4);
        chk_eq("R5 byte1 at base+1", mem8[8'hFF], 8'hC3);
        chk_eq("R5 byte2 at base+2", mem8[8'h00], 8'hB2);
        chk_eq("R5 byte3 at base+3", mem8[8'h01], 8'hA1);
        chk_eq("R2 upper address carried", a_hi, 8'h13);
        chk_eq("R2 lower address last beat", a_lo, 16'h0001);
    endtask

    task automatic t_byte_read;
        logic [31:0] rd;
        mem8[8'h40] = 8'h11; mem8[8'h41] = 8'h22;
        mem8[8'h42] = 8'h33; mem8[8'h43] = 8'h44;
        do_xfer(1'b0, 24'h050040, 32'hFFFFFFFF, 1'b0, 5'd0, 1'b0, rd);
        chk_phys(1'b0, 5'd0);
        chk_eq("R7 byte read packing", rd, 32'h44332211);
        chk_eq("R2 upper address latched", a_hi, 8'h05);
    endtask

    task automatic t_half_write;
        logic [31:0] rd;
        do_xfer(1'b1, 24'h00AB10, 32'hCAFEBEEF, 1'b1, 5'd1, 1'b0, rd);
        chk_phys(1'b1, 5'd1);
        chk_eq("R6 low half at base", mem16[8'h10], 16'hBEEF);
        chk_eq("R6 high half at base+1", mem16[8'h11], 16'hCAFE);
        chk_eq("R3 address last beat", a_lo, 16'hAB11);
    endtask

    task automatic t_half_read;
        logic [31:0] rd;
        mem16[8'h80] = 16'h1357; mem16[8'h81] = 16'h9BDF;
        do_xfer(1'b0, 24'h000080, 32'h0, 1'b1, 5'd31, 1'b0, rd);
        chk_phys(1'b1, 5'd31);
        chk_eq("R8 halfword read packing", rd, 32'h9BDF1357);
    endtask

    task automatic t_cfg_capture;
        logic [31:0] rd;
        do_xfer(1'b0, 24'h000040, 32'h0, 1'b0, 5'd4, 1'b1, rd);
        chk_eq("R11 ale cycles unchanged", ale_cnt, 8);
        chk_eq("R11 strobe count unchanged", strb_cnt, 4);
        chk_eq("R11 strobe width held", strb_max, 4);
        chk_eq("R11 strobe width held min", strb_min, 4);
        chk_eq("R11 read data", rd, 32'h44332211);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem8[i] = 8'h00;
            mem16[i] = 16'h0000;
        end
        t_reset();
        t_byte_write();
        t_byte_read();
        t_half_write();
        t_half_read();
        t_cfg_capture();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule